// File: doc/BRIEF.md
# Transmit Collision and Event Status Encoder

This block sits beside a half-duplex Ethernet transmit MAC and collects everything that happened while one packet was being sent: collisions, deferral time, carrier loss, late (out-of-window) collisions, FIFO underrun and abort. A start pulse clears the collected state. An end pulse captures it as an 11-bit status word that software places in bits 26 down to 16 of the final transmit descriptor of the packet.

There are two ways to report the collision count, selected by a retry-mode input. With retry mode off, the 4-bit count is the plain number of collisions. With retry mode on, collisions are grouped in blocks of sixteen. The upper two count bits hold the number of complete blocks, and the lower two bits flag whether one, or more than one, collision is left over. Deferral time is measured in ticks of an external timebase, and the excessive-deferral threshold is a parameter in ticks. The default is 32 ticks of 100 us, which is the 3.2 ms limit.

The MAC keeps its own backoff and transmit sequencing. This block only observes the MAC's strobes.

Top module: `tx_status_encoder`

## Requirements
- R1: After reset, `status_o` is 0, `status_valid_o` is 0 and `xcol_fail_o` is 0.
- R2: An `eop_i` pulse latches the status on the next clock edge. `status_valid_o` is high for exactly that one cycle, and `status_o`/`xcol_fail_o` then hold until the next `eop_i`. The bit mapping is `status_o[10]` abort, `[9]` underrun, `[8]` carrier lost, `[7]` deferred, `[6]` excessive deferral, `[5]` out-of-window collision, `[4]` excessive collisions and `[3:0]` collision count. These are descriptor bits 26..16.
- R3: A `sop_i` pulse discards everything accumulated for the previous packet. A packet with no events after its start reports all zeros.
- R4: With `retry_mode_i` = 0 at the end pulse, `[3:0]` equals the number of `col_i` cycles, saturating at 15. `[4]` is set once 16 or more collisions have occurred.
- R5: With `retry_mode_i` = 1, `[3:2]` is the number of whole groups of 16 collisions, saturating at 3. With r = collisions mod 16, `[1]` is set when r >= 2 and `[0]` is set when r = 1. For example, 33 collisions give 4'b1001.
- R6: With `retry_mode_i` = 1, `[4]` is set at 64 collisions and clear at 63.
- R7: `xcol_fail_o` equals the latched `[4]`.
- R8: A `crs_lost_i` strobe sets `[8]` only if `cs_ignore_i` is low in the same cycle.
- R9: `[7]` is set if `defer_i` was high in any cycle since the start pulse.
- R10: `[6]` is set when the number of cycles with both `defer_i` and `tick_i` high since the start pulse exceeds `DEFER_LIMIT`. Exactly `DEFER_LIMIT` such ticks leave it clear.
- R11: `abort_i`, `underrun_i` and `owc_i` strobes set `[10]`, `[9]` and `[5]` respectively, and these bits stay set until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_i | input | 1 | Start-of-packet pulse |
| eop_i | input | 1 | End-of-packet pulse, latches status |
| col_i | input | 1 | Collision strobe, one count per cycle high |
| defer_i | input | 1 | MAC is deferring this cycle |
| tick_i | input | 1 | Deferral timebase tick |
| crs_lost_i | input | 1 | Carrier-lost strobe |
| owc_i | input | 1 | Out-of-window collision strobe |
| underrun_i | input | 1 | Transmit FIFO underrun strobe |
| abort_i | input | 1 | Transmit abort strobe |
| retry_mode_i | input | 1 | Selects grouped collision encoding |
| cs_ignore_i | input | 1 | Suppresses carrier-lost reporting |
| status_o | output | 11 | Latched status (descriptor bits 26..16) |
| status_valid_o | output | 1 | One-cycle pulse when status_o updates |
| xcol_fail_o | output | 1 | Latched excessive-collision failure |

## Verification
A wrong collision tally shows up only in the status word of the packet it corrupted. It appears one cycle after the end pulse, as a wrong count nibble or a wrong failure bit. Because of this, the counts are chosen to sit on the encoding edges: 15/16 collisions in plain mode, and 33, 63 and 64 collisions in grouped mode.

A deferral counter that fails to clear or saturate would show up as a wrong bit 6 in the packet that follows. The bench therefore tests counts of `DEFER_LIMIT` and `DEFER_LIMIT`+1, and runs a clean packet after a heavy one.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam int STAT_W = 11;

  typedef struct packed {
    logic       abort;
    logic       underrun;
    logic       crs_lost;
    logic       deferred;
    logic       xdefer;
    logic       owc;
    logic       xcoll;
    logic [3:0] ccnt;
  } tx_stat_t;
endpackage

// File: rtl/coll_tally.sv
module coll_tally #(
  parameter int GROUP       = 16,
  parameter int FAIL_GROUPS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       hit,
  input  logic       retry,
  output logic [3:0] ccnt,
  output logic       xcoll
);
  localparam int MAXC = GROUP * FAIL_GROUPS;
  localparam int TW   = $clog2(MAXC + 1);

  logic [TW-1:0] total;
  logic [TW-1:0] grp;
  logic [TW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      total <= hit ? TW'(1) : '0;
    end else if (hit && total != TW'(MAXC)) begin
      total <= total + TW'(1);
    end
  end

  always_comb begin
    grp = total / TW'(GROUP);
    rem = total % TW'(GROUP);
    if (!retry) begin
      ccnt  = (total >= TW'(15)) ? 4'd15 : 4'(total);
      xcoll = (total >= TW'(GROUP));
    end else begin
      ccnt[3:2] = (grp > TW'(3)) ? 2'd3 : 2'(grp);
      ccnt[1]   = (rem >= TW'(2));
      ccnt[0]   = (rem == TW'(1));
      xcoll     = (total >= TW'(MAXC));
    end
  end

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> total >= $past(total));
  assert_start_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr && !hit |=> total == '0);
  assert_saturate_R6: assert property (@(posedge clk) disable iff (rst)
    total <= TW'(MAXC));
endmodule

// File: rtl/defer_watch.sv
module defer_watch #(
  parameter int DEFER_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic defer,
  input  logic tick,
  output logic deferred,
  output logic xdefer
);
  localparam int CW   = $clog2(DEFER_LIMIT + 2);
  localparam int CTOP = DEFER_LIMIT + 1;

  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= (defer && tick) ? CW'(1) : '0;
      seen <= defer;
    end else begin
      seen <= seen | defer;
      if (defer && tick && cnt != CW'(CTOP)) cnt <= cnt + CW'(1);
    end
  end

  assign deferred = seen;
  assign xdefer   = (cnt > CW'(DEFER_LIMIT));

  assert_xdefer_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(xdefer) |-> $past(defer && tick));
  assert_deferred_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(deferred) |-> $past(defer));
endmodule

// File: rtl/evt_flags.sv
module evt_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic abort,
  input  logic underrun,
  input  logic owc,
  input  logic crs_lost,
  input  logic cs_ignore,
  output logic f_abort,
  output logic f_underrun,
  output logic f_owc,
  output logic f_crs
);
  logic crs_take;
  assign crs_take = crs_lost && !cs_ignore;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      f_abort    <= abort;
      f_underrun <= underrun;
      f_owc      <= owc;
      f_crs      <= crs_take;
    end else begin
      f_abort    <= f_abort | abort;
      f_underrun <= f_underrun | underrun;
      f_owc      <= f_owc | owc;
      f_crs      <= f_crs | crs_take;
    end
  end

  assert_crs_masked_R8: assert property (@(posedge clk) disable iff (rst)
    !clr && !f_crs && (!crs_lost || cs_ignore) |=> !f_crs);
  assert_abort_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    f_abort && !clr |=> f_abort);
endmodule

// File: rtl/tx_status_encoder.sv
module tx_status_encoder #(
  parameter int GROUP       = 16,
  parameter int FAIL_GROUPS = 4,
  parameter int DEFER_LIMIT = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sop_i,
  input  logic        eop_i,
  input  logic        col_i,
  input  logic        defer_i,
  input  logic        tick_i,
  input  logic        crs_lost_i,
  input  logic        owc_i,
  input  logic        underrun_i,
  input  logic        abort_i,
  input  logic        retry_mode_i,
  input  logic        cs_ignore_i,
  output logic [10:0] status_o,
  output logic        status_valid_o,
  output logic        xcol_fail_o
);
  import tx_stat_pkg::*;

  tx_stat_t cur;

  coll_tally #(.GROUP(GROUP), .FAIL_GROUPS(FAIL_GROUPS)) u_coll (
    .clk(clk), .rst(rst), .clr(sop_i), .hit(col_i), .retry(retry_mode_i),
    .ccnt(cur.ccnt), .xcoll(cur.xcoll)
  );

  defer_watch #(.DEFER_LIMIT(DEFER_LIMIT)) u_defer (
    .clk(clk), .rst(rst), .clr(sop_i), .defer(defer_i), .tick(tick_i),
    .deferred(cur.deferred), .xdefer(cur.xdefer)
  );

  evt_flags u_flags (
    .clk(clk), .rst(rst), .clr(sop_i), .abort(abort_i), .underrun(underrun_i),
    .owc(owc_i), .crs_lost(crs_lost_i), .cs_ignore(cs_ignore_i),
    .f_abort(cur.abort), .f_underrun(cur.underrun), .f_owc(cur.owc),
    .f_crs(cur.crs_lost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o       <= '0;
      status_valid_o <= 1'b0;
      xcol_fail_o    <= 1'b0;
    end else begin
      status_valid_o <= eop_i;
      if (eop_i) begin
        status_o    <= cur;
        xcol_fail_o <= cur.xcoll;
      end
    end
  end

  assert_valid_after_end_R2: assert property (@(posedge clk) disable iff (rst)
    status_valid_o |-> $past(eop_i));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !eop_i |=> $stable(status_o));
  assert_fail_bit_R7: assert property (@(posedge clk) disable iff (rst)
    xcol_fail_o == status_o[4]);
  assert_plain_sat_R4: assert property (@(posedge clk) disable iff (rst)
    status_valid_o && status_o[4] && !$past(retry_mode_i) |-> status_o[3:0] == 4'hF);
endmodule

// File: tb/tx_status_encoder_test.sv
module tx_status_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sop_i = 0, eop_i = 0, col_i = 0, defer_i = 0, tick_i = 0;
  logic crs_lost_i = 0, owc_i = 0, underrun_i = 0, abort_i = 0;
  logic retry_mode_i = 0, cs_ignore_i = 0;
  logic [10:0] status_o;
  logic status_valid_o, xcol_fail_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [11:0] qv[$];
  string qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_status_encoder #(.GROUP(16), .FAIL_GROUPS(4), .DEFER_LIMIT(DL)) uut (
    .clk(clk), .rst(rst), .sop_i(sop_i), .eop_i(eop_i), .col_i(col_i),
    .defer_i(defer_i), .tick_i(tick_i), .crs_lost_i(crs_lost_i), .owc_i(owc_i),
    .underrun_i(underrun_i), .abort_i(abort_i), .retry_mode_i(retry_mode_i),
    .cs_ignore_i(cs_ignore_i), .status_o(status_o),
    .status_valid_o(status_valid_o), .xcol_fail_o(xcol_fail_o)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && status_valid_o) begin
      if (qv.size() == 0) begin
        check("R2 unexpected valid", {xcol_fail_o, status_o}, 12'hxxx);
      end else begin
        logic [11:0] e;
        string t;
        e = qv.pop_front();
        t = qt.pop_front();
        check(t, {xcol_fail_o, status_o}, e);
      end
    end
  end

  task automatic run_pkt(input string tag, input int ncol, input bit retry,
                         input bit crs, input bit csign, input int dcyc,
                         input bit ab, input bit un, input bit ow);
    int tot;
    logic [3:0] cc;
    bit ec;
    logic [10:0] st;
    tot = (ncol > 64) ? 64 : ncol;
    if (!retry) begin
      cc = (tot >= 15) ? 4'd15 : 4'(tot);
      ec = (tot >= 16);
    end else begin
      int g;
      int r;
      g = tot / 16;
      r = tot % 16;
      cc[3:2] = (g > 3) ? 2'd3 : 2'(g);
      cc[1] = (r >= 2);
      cc[0] = (r == 1);
      ec = (tot >= 64);
    end
    st = {ab, un, crs && !csign, dcyc > 0, dcyc > DL, ow, ec, cc};
    qv.push_back({ec, st});
    qt.push_back(tag);
    @(negedge clk);
    retry_mode_i = retry; cs_ignore_i = csign; sop_i = 1;
    @(negedge clk); sop_i = 0;
    for (int i = 0; i < ncol; i++) begin col_i = 1; @(negedge clk); end
    col_i = 0;
    if (crs) begin crs_lost_i = 1; @(negedge clk); crs_lost_i = 0; end
    for (int i = 0; i < dcyc; i++) begin defer_i = 1; tick_i = 1; @(negedge clk); end
    defer_i = 0; tick_i = 0;
    if (ab || un || ow) begin
      abort_i = ab; underrun_i = un; owc_i = ow;
      @(negedge clk);
      abort_i = 0; underrun_i = 0; owc_i = 0;
    end
    eop_i = 1; @(negedge clk); eop_i = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {status_valid_o, xcol_fail_o, status_o[9:0]},
          12'h000);
    check("R1 reset status top bit", {11'b0, status_o[10]}, 12'h000);
    rst = 0;
    @(negedge clk);
    run_pkt("R2 clean packet", 0, 0, 0, 0, 0, 0, 0, 0);
    run_pkt("R4 five collisions", 5, 0, 0, 0, 0, 0, 0, 0);
    run_pkt("R4 fifteen collisions", 15, 0, 0, 0, 0, 0, 0, 0);
    run_pkt("R4 R7 sixteen collisions", 16, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    check("R2 hold after packet", {status_valid_o, xcol_fail_o, status_o[9:0]},
          {1'b0, 1'b1, 10'h01F});
    run_pkt("R5 33 collisions grouped", 33, 1, 0, 0, 0, 0, 0, 0);
    run_pkt("R5 18 collisions grouped", 18, 1, 0, 0, 0, 0, 0, 0);
    run_pkt("R6 63 collisions grouped", 63, 1, 0, 0, 0, 0, 0, 0);
    run_pkt("R6 R7 64 collisions grouped", 64, 1, 0, 0, 0, 0, 0, 0);
    run_pkt("R8 carrier lost reported", 0, 0, 1, 0, 0, 0, 0, 0);
    run_pkt("R8 carrier lost ignored", 0, 0, 1, 1, 0, 0, 0, 0);
    run_pkt("R9 short deferral", 0, 0, 0, 0, 3, 0, 0, 0);
    run_pkt("R10 deferral at limit", 0, 0, 0, 0, DL, 0, 0, 0);
    run_pkt("R10 deferral over limit", 0, 0, 0, 0, DL + 1, 0, 0, 0);
    run_pkt("R11 abort underrun late collision", 2, 0, 0, 0, 0, 1, 1, 1);
    run_pkt("R3 heavy packet", 20, 1, 1, 0, DL + 3, 1, 0, 1);
    run_pkt("R3 clean after heavy", 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R2 all results seen", {11'b0, qv.size() != 0}, 12'h000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule